// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Override

The block serializes bytes from an internal transmit queue onto a single output line, one frame per byte. A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit and a high stop bit. Every bit lasts 16 or 8 base-clock ticks, as the rate input selects. The base-clock tick is an enable input from an external rate generator, so the block itself does no baud generation.

A transmit-enable input decides who owns the line. While it is high, the serializer drives the line, and an idle serializer holds it at mark (high). While it is low, two port-override register bits drive the line directly. One bit sets the output enable and the other sets the level. Dropping the enable resets the serializer at once, even mid-frame, and the line takes the override level in the same cycle. To send a break, software first writes the override level to 0 and then drops the enable. The line then stays low for as long as the enable stays low.

A request output asks for more data while the queue holds no more than a programmable number of bytes. A sticky end flag reports that the last frame has fully left the line and the queue is empty.

Top module: `async_tx_brk`

## Requirements
- R1: After reset the override bits are output-enable 1 and level 1. With the enable low, `txd_o`=1, `txd_oe_o`=1, `tx_end_o`=1, `fifo_count_o`=0 and `fifo_full_o`=0.
- R2: While `tx_en_i`=0, `txd_oe_o` and `txd_o` equal the override bits last written through `port_wr_i`. No frame starts, and queued bytes stay in the queue.
- R3: With `half_rate_i`=0 and `par_en_i`=0, a frame is a start bit 0, then data bits 0 to 7, then a stop bit 1, and each bit lasts 16 ticks.
- R4: With `half_rate_i`=1, each bit lasts 8 ticks.
- R5: With `par_en_i`=1, a parity bit follows data bit 7. It is the XOR of the 8 data bits when `par_odd_i`=0 and the inverse of that XOR when `par_odd_i`=1.
- R6: Bit time advances only on cycles where `tick_i`=1.
- R7: When `tx_en_i` falls mid-frame, the line shows the override level in the same cycle. The aborted byte is discarded. After re-enable, the next queued byte goes out as a complete fresh frame, and an empty queue leaves the line at mark.
- R8: After the override level is written to 0 and `tx_en_i` is then cleared, `txd_o` stays 0 with `txd_oe_o`=1 until the override is rewritten or transmission is re-enabled.
- R9: The queue holds DEPTH bytes and sends them in write order. A write while `fifo_full_o`=1 is dropped.
- R10: `tx_req_o`=1 exactly when `fifo_count_o` <= `thresh_i`.
- R11: `tx_end_o` sets when the stop bit of a frame completes and the queue is empty. It clears on an accepted write.
- R12: With `tx_en_i`=1 and no frame in progress, `txd_o`=1 and `txd_oe_o`=1, whatever the override bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base-clock tick enable |
| half_rate_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| par_en_i | input | 1 | Insert parity bit |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| tx_en_i | input | 1 | Transmit enable; low hands the line to the override bits |
| port_wr_i | input | 1 | Write strobe for the override bits |
| port_oe_i | input | 1 | Override output-enable value |
| port_dat_i | input | 1 | Override line level value |
| wr_valid_i | input | 1 | Queue write strobe |
| wr_data_i | input | DW (8) | Byte to queue |
| thresh_i | input | $clog2(DEPTH+1) (5) | Request threshold |
| fifo_count_o | output | $clog2(DEPTH+1) (5) | Bytes queued |
| fifo_full_o | output | 1 | Queue full |
| tx_req_o | output | 1 | Request for more data |
| tx_end_o | output | 1 | Line idle and queue empty |
| txd_o | output | 1 | Serial line level |
| txd_oe_o | output | 1 | Serial line output enable |

## Verification
A bit counter or tick counter in the wrong state shows up on `txd_o` within one bit time, as a shifted sample, a wrong parity bit or a missing stop bit. Bit-centre sampling catches this in the same frame. A serializer that survives a drop of the enable shows up either as a line level that differs from the override level in the same cycle, or as the tail of the aborted frame after re-enable. Comparing the next received byte catches the second case. Queue pointer or count faults show up as a wrong `fifo_count_o` or `tx_req_o` right after the writes, or as out-of-order bytes when the queue drains.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int unsigned OVS_FULL = 16;
  localparam int unsigned OVS_HALF = 8;

  typedef enum logic {
    ST_IDLE,
    ST_SHIFT
  } tx_state_e;
endpackage

// File: rtl/async_tx_fifo.sv
module async_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  a_r9_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (count_o == $past(count_o)));
endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter
  import async_tx_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned OVS_FULL_P = OVS_FULL,
  parameter int unsigned OVS_HALF_P = OVS_HALF,
  localparam int unsigned FW        = DW + 3,
  localparam int unsigned TW        = $clog2(OVS_FULL_P),
  localparam int unsigned BW        = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          half_rate_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          avail_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          ser_o,
  output logic          busy_o,
  output logic          done_o
);
  tx_state_e     state_q;
  logic [FW-1:0] shreg_q;
  logic [TW-1:0] tcnt_q, last_tick;
  logic [BW-1:0] bidx_q, nbits_q;
  logic          bit_end, frame_end, par_bit;
  logic [FW-1:0] frame_d;

  assign busy_o    = (state_q == ST_SHIFT);
  assign last_tick = half_rate_i ? TW'(OVS_HALF_P - 1) : TW'(OVS_FULL_P - 1);
  assign bit_end   = busy_o & tick_i & (tcnt_q == last_tick);
  assign frame_end = bit_end & (bidx_q == nbits_q - BW'(1));
  assign pop_o     = en_i & ~busy_o & avail_i;
  assign done_o    = en_i & frame_end;
  assign ser_o     = busy_o ? shreg_q[0] : 1'b1;
  assign par_bit   = (^data_i) ^ par_odd_i;

  // without parity the slot after the data holds a second stop bit, never sent
  assign frame_d = par_en_i ? {1'b1, par_bit, data_i, 1'b0}
                            : {2'b11, data_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '1;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      nbits_q <= BW'(FW - 1);
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      shreg_q <= '1;
      tcnt_q  <= '0;
      bidx_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (avail_i) begin
            shreg_q <= frame_d;
            nbits_q <= par_en_i ? BW'(FW) : BW'(FW - 1);
            tcnt_q  <= '0;
            bidx_q  <= '0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            if (bit_end) begin
              tcnt_q  <= '0;
              shreg_q <= {1'b1, shreg_q[FW-1:1]};
              if (frame_end) state_q <= ST_IDLE;
              else           bidx_q  <= bidx_q + BW'(1);
            end else begin
              tcnt_q <= tcnt_q + TW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !ser_o);

  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && en_i && !tick_i) |=> $stable(ser_o));

  a_r7_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
endmodule

// File: rtl/async_tx_pin_ctl.sv
module async_tx_pin_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ser_i,
  input  logic port_wr_i,
  input  logic port_oe_i,
  input  logic port_dat_i,
  output logic txd_o,
  output logic txd_oe_o
);
  logic oe_q, dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b1;
      dat_q <= 1'b1;
    end else if (port_wr_i) begin
      oe_q  <= port_oe_i;
      dat_q <= port_dat_i;
    end
  end

  // unregistered so an abort hands over the line in the same cycle
  assign txd_o    = en_i ? ser_i : dat_q;
  assign txd_oe_o = en_i | oe_q;

  a_r8_break_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !txd_o && !port_wr_i) |=> (en_i || !txd_o));
endmodule

// File: rtl/async_tx_brk.sv
module async_tx_brk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          half_rate_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          tx_en_i,
  input  logic          port_wr_i,
  input  logic          port_oe_i,
  input  logic          port_dat_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [CW-1:0] thresh_i,
  output logic [CW-1:0] fifo_count_o,
  output logic          fifo_full_o,
  output logic          tx_req_o,
  output logic          tx_end_o,
  output logic          txd_o,
  output logic          txd_oe_o
);
  logic [DW-1:0] q_data;
  logic          q_empty, q_pop, wr_ok;
  logic          sh_ser, sh_busy, sh_done;
  logic          tx_end_q;

  async_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_valid_i),
    .data_i  (wr_data_i),
    .pop_i   (q_pop),
    .data_o  (q_data),
    .count_o (fifo_count_o),
    .full_o  (fifo_full_o),
    .empty_o (q_empty)
  );

  async_tx_shifter #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en_i),
    .tick_i      (tick_i),
    .half_rate_i (half_rate_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .avail_i     (~q_empty),
    .data_i      (q_data),
    .pop_o       (q_pop),
    .ser_o       (sh_ser),
    .busy_o      (sh_busy),
    .done_o      (sh_done)
  );

  async_tx_pin_ctl u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tx_en_i),
    .ser_i      (sh_ser),
    .port_wr_i  (port_wr_i),
    .port_oe_i  (port_oe_i),
    .port_dat_i (port_dat_i),
    .txd_o      (txd_o),
    .txd_oe_o   (txd_oe_o)
  );

  assign wr_ok    = wr_valid_i & ~fifo_full_o;
  assign tx_req_o = (fifo_count_o <= thresh_i);
  assign tx_end_o = tx_end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tx_end_q <= 1'b1;
    else if (wr_ok)               tx_end_q <= 1'b0;
    else if (sh_done && q_empty)  tx_end_q <= 1'b1;
  end

  a_r11_end_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> !tx_end_o);

  a_r11_end_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && q_empty && !wr_valid_i) |=> tx_end_o);

  a_r12_idle_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !sh_busy) |-> (txd_o && txd_oe_o));
endmodule

// File: tb/async_tx_brk_test.sv
`timescale 1ns/1ps
module async_tx_brk_test;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          tick_i = 1'b1;
  logic          half_rate_i, par_en_i, par_odd_i, tx_en_i;
  logic          port_wr_i, port_oe_i, port_dat_i;
  logic          wr_valid_i;
  logic [7:0]    wr_data_i;
  logic [CW-1:0] thresh_i;
  logic [CW-1:0] fifo_count_o;
  logic          fifo_full_o, tx_req_o, tx_end_o, txd_o, txd_oe_o;

  int errors = 0;
  int checks = 0;
  int tick_per = 1;
  int tick_ph = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  async_tx_brk #(.DW(8), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .half_rate_i(half_rate_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .tx_en_i(tx_en_i),
    .port_wr_i(port_wr_i), .port_oe_i(port_oe_i), .port_dat_i(port_dat_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .thresh_i(thresh_i),
    .fifo_count_o(fifo_count_o), .fifo_full_o(fifo_full_o), .tx_req_o(tx_req_o),
    .tx_end_o(tx_end_o), .txd_o(txd_o), .txd_oe_o(txd_oe_o)
  );

  always @(negedge clk) begin
    if (tick_ph >= tick_per - 1) begin
      tick_ph <= 0;
      tick_i  <= 1'b1;
    end else begin
      tick_ph <= tick_ph + 1;
      tick_i  <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    wr_valid_i = 1'b1;
    wr_data_i  = b;
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic port_set(input logic oe, input logic dat);
    port_wr_i  = 1'b1;
    port_oe_i  = oe;
    port_dat_i = dat;
    @(negedge clk);
    port_wr_i  = 1'b0;
  endtask

  task automatic wait_start(input string tag);
    int w = 0;
    while (txd_o !== 1'b0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk({tag, " start edge seen"}, int'(w < 5000), 1);
  endtask

  task automatic recv(input string tag, input int nt, input logic [7:0] exp);
    int bitc = nt * tick_per;
    logic [7:0] d;
    wait_start(tag);
    repeat (bitc / 2) @(negedge clk);
    chk({tag, " start bit"}, int'(txd_o), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bitc) @(negedge clk);
      d[i] = txd_o;
    end
    chk({tag, " data byte"}, int'(d), int'(exp));
    if (par_en_i) begin
      repeat (bitc) @(negedge clk);
      chk({tag, " parity bit"}, int'(txd_o), int'((^exp) ^ par_odd_i));
    end
    repeat (bitc) @(negedge clk);
    chk({tag, " stop bit"}, int'(txd_o), 1);
  endtask

  task automatic end_after_stop(input string tag, input int nt);
    repeat (nt * tick_per / 2 + tick_per + 3) @(negedge clk);
    chk({tag, " end flag after last stop"}, int'(tx_end_o), 1);
  endtask

  task automatic t_reset;
    chk("R1 txd after reset", int'(txd_o), 1);
    chk("R1 oe after reset", int'(txd_oe_o), 1);
    chk("R1 end flag after reset", int'(tx_end_o), 1);
    chk("R1 count after reset", int'(fifo_count_o), 0);
    chk("R1 full after reset", int'(fifo_full_o), 0);
    chk("R10 request with empty queue", int'(tx_req_o), 1);
  endtask

  task automatic t_override;
    port_set(1'b0, 1'b0);
    chk("R2 oe follows override", int'(txd_oe_o), 0);
    chk("R2 level follows override", int'(txd_o), 0);
    wr_byte(8'h3A);
    chk("R11 end flag cleared by write", int'(tx_end_o), 0);
    repeat (200) @(negedge clk);
    chk("R2 byte held while disabled", int'(fifo_count_o), 1);
    chk("R2 line still override while disabled", int'(txd_o), 0);
    port_set(1'b1, 1'b1);
    chk("R2 level override high", int'(txd_o), 1);
    tx_en_i = 1'b1;
    recv("R3 held byte", 16, 8'h3A);
    end_after_stop("R11 held byte", 16);
  endtask

  task automatic t_basic;
    port_set(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R12 idle mark level while enabled", int'(txd_o), 1);
    chk("R12 idle oe while enabled", int'(txd_oe_o), 1);
    port_set(1'b1, 1'b1);
    wr_byte(8'hA5);
    recv("R3 byte A5", 16, 8'hA5);
    end_after_stop("R11 byte A5", 16);
    wr_byte(8'h01);
    recv("R3 byte 01", 16, 8'h01);
  endtask

  task automatic t_half;
    repeat (5) @(negedge clk);
    half_rate_i = 1'b1;
    wr_byte(8'h3C);
    recv("R4 half rate byte 3C", 8, 8'h3C);
    wr_byte(8'hC2);
    recv("R4 half rate byte C2", 8, 8'hC2);
    end_after_stop("R4 half rate", 8);
    half_rate_i = 1'b0;
  endtask

  task automatic t_parity;
    par_en_i  = 1'b1;
    par_odd_i = 1'b0;
    wr_byte(8'h07);
    recv("R5 even parity 07", 16, 8'h07);
    end_after_stop("R5 even", 16);
    par_odd_i = 1'b1;
    wr_byte(8'h07);
    recv("R5 odd parity 07", 16, 8'h07);
    end_after_stop("R5 odd", 16);
    par_en_i  = 1'b0;
    par_odd_i = 1'b0;
  endtask

  task automatic t_tick;
    tick_per = 3;
    repeat (6) @(negedge clk);
    wr_byte(8'h96);
    recv("R6 sparse ticks 96", 16, 8'h96);
    end_after_stop("R6 sparse ticks", 16);
    tick_per = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_abort;
    wr_byte(8'h00);
    wait_start("R7 abort frame");
    repeat (3 * 16) @(negedge clk);
    chk("R7 mid-frame data low", int'(txd_o), 0);
    tx_en_i = 1'b0;
    #1;
    chk("R7 override level at once", int'(txd_o), 1);
    chk("R7 override oe at once", int'(txd_oe_o), 1);
    @(negedge clk);
    tx_en_i = 1'b1;
    repeat (40) @(negedge clk);
    chk("R7 aborted frame not resumed", int'(txd_o), 1);
  endtask

  task automatic t_break;
    wr_byte(8'h55);
    wr_byte(8'h81);
    wait_start("R8 break frame");
    repeat (2 * 16 + 8) @(negedge clk);
    port_set(1'b1, 1'b0);
    tx_en_i = 1'b0;
    #1;
    chk("R8 break low at once", int'(txd_o), 0);
    for (int k = 0; k < 8; k++) begin
      repeat (50) @(negedge clk);
      chk("R8 break held low", int'(txd_o), 0);
      chk("R8 break oe held", int'(txd_oe_o), 1);
    end
    chk("R7 queued byte kept over abort", int'(fifo_count_o), 1);
    port_set(1'b1, 1'b1);
    chk("R8 break released by override", int'(txd_o), 1);
    tx_en_i = 1'b1;
    recv("R7 fresh frame after abort", 16, 8'h81);
    end_after_stop("R7 fresh frame", 16);
  endtask

  task automatic t_fifo;
    tx_en_i  = 1'b0;
    thresh_i = CW'(3);
    @(negedge clk);
    for (int k = 0; k < DEPTH + 2; k++) begin
      wr_byte(8'(k * 7 + 1));
      if (k == 2) chk("R10 request at threshold", int'(tx_req_o), 1);
      if (k == 3) chk("R10 no request above threshold", int'(tx_req_o), 0);
    end
    chk("R9 count at depth", int'(fifo_count_o), DEPTH);
    chk("R9 full flag", int'(fifo_full_o), 1);
    tx_en_i = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      recv("R9 drain order", 16, 8'(k * 7 + 1));
    end
    end_after_stop("R11 drained queue", 16);
    chk("R9 no dropped byte sent", int'(fifo_count_o), 0);
    chk("R10 request after drain", int'(tx_req_o), 1);
  endtask

  initial begin
    rst_ni = 1'b0;
    half_rate_i = 1'b0; par_en_i = 1'b0; par_odd_i = 1'b0; tx_en_i = 1'b0;
    port_wr_i = 1'b0; port_oe_i = 1'b0; port_dat_i = 1'b0;
    wr_valid_i = 1'b0; wr_data_i = '0; thresh_i = CW'(2);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_override();
    t_basic();
    t_half();
    t_parity();
    t_tick();
    t_abort();
    t_break();
    t_fifo();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule